// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Controller

This block connects a simple on-chip request port to an external asynchronous static RAM. The RAM is byte-wide and has an 18-bit address. A requester raises a valid flag together with a direction bit, an address and a write byte. The request is accepted only while the controller is idle. When the access is complete, the controller pulses a one-clock acknowledge. For reads, the fetched byte is presented alongside that acknowledge.

On the memory side the controller drives three active-low strobes (chip select, output enable and write enable), the address bus, and a tri-state data bus. Every access runs as a fixed sequence of clock-counted phases. The length of each phase is derived at elaboration time from nanosecond timing parameters and the clock period, always rounded up and never shorter than one clock. This meets the memory's limits on setup, pulse width, hold, cycle time and bus turnaround.

Output enable is held high for the whole of a write, so the shorter write-pulse minimum applies. The data driver is released one clock after write enable returns high. Chip select stays low across back-to-back requests, and only the two data strobes toggle between them.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no request pending, chip select, output enable and write enable are all high, ready is high and acknowledge is low.
- R2: During a read, output enable is low and write enable is high for exactly RD_CYC clocks. RD_CYC is the largest of the rounded address-access time, output-enable access time and read cycle time. The acknowledge follows in the next clock and carries the byte the memory presented.
- R3: Output enable stays high for the whole of a write, and write enable is low for exactly WP_CYC consecutive clocks. WP_CYC is the largest of the rounded pulse width, data setup time and address-to-write-end time.
- R4: After a write request is accepted, write enable falls only once WS_CYC clocks have passed. WS_CYC is the larger of the rounded address setup time and the output float time after output enable rises.
- R5: The write byte is on the data bus while write enable is low and for at least one clock after write enable rises, and the memory stores that byte.
- R6: A write is acknowledged WS_CYC+WP_CYC+WH_CYC+1 clocks after acceptance. WH_CYC is the rounded write cycle time minus WS_CYC and WP_CYC, but never less than one clock.
- R7: Acknowledge is high for exactly one clock. Ready is low from acceptance until acknowledge. A request presented while busy is ignored and writes nothing.
- R8: When a new request is presented in the clock in which acknowledge is high, chip select stays low without a break into the next access.
- R9: If no request is presented in the acknowledge clock, chip select goes high one clock later.
- R10: The memory address equals the accepted request address and holds steady for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Request address |
| req_wdata_i | input | 8 | Write byte |
| req_ready_o | output | 1 | Controller idle, request may be accepted |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Read byte, valid with ack_o |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_addr_o | output | 18 | Memory address |
| mem_data_io | inout | 8 | Bidirectional memory data bus |

## Verification
The bench builds the controller with a 3 ns clock-period parameter while keeping the default nanosecond limits. This turns every phase into a multi-clock phase: two setup clocks, a three-clock write pulse, one hold clock and four read clocks. As a result, the rounding and the maximum-taking between competing limits can be observed at the strobes. A 64-byte memory model on the bus is swept in full with writes and read-backs. The sweep also covers back-to-back alternation and requests injected while the controller is busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WSET, ST_WPULSE, ST_WHOLD
  } state_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RD_CYC  = 1,
  parameter int unsigned WS_CYC  = 1,
  parameter int unsigned WP_CYC  = 1,
  parameter int unsigned WH_CYC  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             done_i,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             ack_o,
  output logic             ce_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             drv_en_o
);
  state_e state_q, state_d;

  assign ready_o   = (state_q == ST_IDLE);
  assign accept_o  = ready_o && req_valid_i;
  assign capture_o = (state_q == ST_RD) && done_i;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    len_o   = '0;
    unique case (state_q)
      ST_IDLE: if (accept_o) begin
        load_o = 1'b1;
        if (req_write_i) begin state_d = ST_WSET; len_o = CNT_W'(WS_CYC); end
        else             begin state_d = ST_RD;   len_o = CNT_W'(RD_CYC); end
      end
      ST_RD:     if (done_i) state_d = ST_IDLE;
      ST_WSET:   if (done_i) begin state_d = ST_WPULSE; load_o = 1'b1; len_o = CNT_W'(WP_CYC); end
      ST_WPULSE: if (done_i) begin state_d = ST_WHOLD;  load_o = 1'b1; len_o = CNT_W'(WH_CYC); end
      ST_WHOLD:  if (done_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ce_n_o   <= 1'b1;
      oe_n_o   <= 1'b1;
      we_n_o   <= 1'b1;
      drv_en_o <= 1'b0;
      ack_o    <= 1'b0;
    end else begin
      state_q  <= state_d;
      // chip select only rises from an idle cycle with no new request
      ce_n_o   <= (state_q == ST_IDLE) && !accept_o;
      oe_n_o   <= (state_d != ST_RD);
      we_n_o   <= (state_d != ST_WPULSE);
      drv_en_o <= (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
      ack_o    <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
    end
  end
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
    end else begin
      if (accept_i) begin
        addr_o  <= req_addr_i;
        wdata_o <= req_wdata_i;
      end
      if (capture_i) rdata_o <= bus_i;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_AA_NS       = 10,
  parameter int unsigned T_DOE_NS      = 4,
  parameter int unsigned T_RC_NS       = 10,
  parameter int unsigned T_AS_NS       = 0,
  parameter int unsigned T_PWE_NS      = 8,
  parameter int unsigned T_SD_NS       = 5,
  parameter int unsigned T_AW_NS       = 8,
  parameter int unsigned T_WC_NS       = 10,
  parameter int unsigned T_HA_NS       = 0,
  parameter int unsigned T_HZOE_NS     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  inout  wire  [DATA_W-1:0] mem_data_io
);
  localparam int unsigned P       = CLK_PERIOD_NS;
  localparam int unsigned RD_CYC  = max2(max2(ns2cyc(T_AA_NS, P), ns2cyc(T_DOE_NS, P)),
                                         ns2cyc(T_RC_NS, P));
  localparam int unsigned WS_CYC  = max2(ns2cyc(T_AS_NS, P), ns2cyc(T_HZOE_NS, P));
  localparam int unsigned WP_CYC  = max2(max2(ns2cyc(T_PWE_NS, P), ns2cyc(T_SD_NS, P)),
                                         ns2cyc(T_AW_NS, P));
  localparam int unsigned WC_CYC  = ns2cyc(T_WC_NS, P);
  localparam int unsigned WH_CYC  = max2(ns2cyc(T_HA_NS, P),
                                         (WC_CYC > WS_CYC + WP_CYC) ? WC_CYC - WS_CYC - WP_CYC : 1);

  logic             load, done, accept, capture, drv_en;
  logic [CNT_W-1:0] len;
  logic [DATA_W-1:0] wdata_q;

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni, .load_i(load), .len_i(len), .done_o(done)
  );

  sram_ctrl_fsm #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .WS_CYC(WS_CYC), .WP_CYC(WP_CYC), .WH_CYC(WH_CYC)
  ) i_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i,
    .done_i(done), .load_o(load), .len_o(len),
    .accept_o(accept), .capture_o(capture),
    .ready_o(req_ready_o), .ack_o(ack_o),
    .ce_n_o(mem_ce_no), .oe_n_o(mem_oe_no), .we_n_o(mem_we_no),
    .drv_en_o(drv_en)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk_i, .rst_ni,
    .accept_i(accept), .capture_i(capture),
    .req_addr_i, .req_wdata_i,
    .bus_i(mem_data_io),
    .addr_o(mem_addr_o), .wdata_o(wdata_q), .rdata_o(rdata_o)
  );

  assign mem_data_io = drv_en ? wdata_q : {DATA_W{1'bz}};

  assert_oe_high_in_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no);
  assert_no_drive_on_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !drv_en);
  assert_hold_after_we_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> drv_en);
  assert_ack_one_clock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  assert_strobe_needs_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> !mem_ce_no);
  assert_addr_steady_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> $stable(mem_addr_o));
endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;
  localparam int P = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, ack, ce_n, oe_n, we_n;
  logic [7:0]  rdata;
  logic [17:0] maddr;
  wire  [7:0]  mdata;

  int checks = 0, fails = 0;
  bit armed = 0;
  logic [7:0] mdl [64];
  logic [7:0] golden [64];

  always #10 clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_NS(P)) i_sram_async_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(ready), .ack_o(ack), .rdata_o(rdata),
    .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_addr_o(maddr), .mem_data_io(mdata)
  );

  // memory model
  wire mdl_drive = !ce_n && !oe_n && we_n;
  assign mdata = mdl_drive ? mdl[maddr[5:0]] : 8'hzz;
  always @(posedge we_n) if (armed && !ce_n) mdl[maddr[5:0]] <= mdata;

  function automatic int cdiv(input int ns);
    int c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int RDC, WS, WP, WCC, WH;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at a negedge where ready is high; returns at the negedge where ack is seen
  task automatic access(input bit wr, input logic [17:0] a, input logic [7:0] d,
                        input bit poke, input bit b2b, output logic [7:0] rd);
    int n = 0, we_cnt = 0, we_first = 0, oe_cnt = 0, wr_oe_bad = 0;
    int addr_bad = 0, busy_rdy = 0, ce_break = 0, hold_bad = 0, hold_seen = 0;
    logic prev_we = 1;
    chk(ready == 1, "R7 ready before request", ready, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk); n++;
      if (n == 1) begin
        if (poke) begin req_valid = 1; req_write = 1; req_addr = 18'd63; req_wdata = 8'hEE; end
        else req_valid = 0;
      end else if (n == 2) req_valid = 0;
      if (!ack) begin
        if (!we_n) begin we_cnt++; if (we_first == 0) we_first = n; end
        if (!oe_n) oe_cnt++;
        if (wr && !oe_n) wr_oe_bad++;
        if (maddr != a) addr_bad++;
        if (ready) busy_rdy++;
        if (ce_n) ce_break++;
        if (wr && !prev_we && we_n) begin hold_seen++; if (mdata != d) hold_bad++; end
        prev_we = we_n;
      end
    end while (!ack && n < 60);
    chk(n < 60, "watchdog access", n, 0);
    chk(addr_bad == 0, "R10 address steady", addr_bad, 0);
    chk(busy_rdy == 0, "R7 ready low while busy", busy_rdy, 0);
    chk(ce_break == 0, b2b ? "R8 chip select continuous" : "R2 chip select low", ce_break, 0);
    if (wr) begin
      chk(wr_oe_bad == 0, "R3 oe high during write", wr_oe_bad, 0);
      chk(we_cnt == WP, "R3 write pulse clocks", we_cnt, WP);
      chk(we_first == WS + 1, "R4 setup before we falls", we_first - 1, WS);
      chk(n == WS + WP + WH + 1, "R6 write ack latency", n, WS + WP + WH + 1);
      chk(hold_seen == 1 && hold_bad == 0, "R5 data held after we rises", hold_bad, 0);
    end else begin
      chk(oe_cnt == RDC, "R2 oe low clocks", oe_cnt, RDC);
      chk(we_cnt == 0, "R2 we high on read", we_cnt, 0);
      chk(n == RDC + 1, "R2 read ack latency", n, RDC + 1);
    end
    rd = rdata;
  endtask

  task automatic idle_after();
    @(negedge clk);
    chk(ack == 0, "R7 ack one clock", ack, 0);
    chk(ce_n == 1, "R9 chip select released", ce_n, 1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] r;
    RDC = mx(mx(cdiv(10), cdiv(4)), cdiv(10));
    WS  = mx(cdiv(0), cdiv(4));
    WP  = mx(mx(cdiv(8), cdiv(5)), cdiv(8));
    WCC = cdiv(10);
    WH  = mx(cdiv(0), (WCC > WS + WP) ? WCC - WS - WP : 1);
    for (int i = 0; i < 64; i++) begin mdl[i] = 8'(i) ^ 8'hA5; golden[i] = 8'(i) ^ 8'hA5; end

    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n, "R1 strobes high in reset", {ce_n, oe_n, we_n}, 7);
    chk(ready == 1 && ack == 0, "R1 ready/ack in reset", {ready, ack}, 2);
    rst_n = 1; armed = 1;
    repeat (2) @(negedge clk);
    chk(ce_n && oe_n && we_n, "R1 strobes high after reset", {ce_n, oe_n, we_n}, 7);
    chk(ready == 1 && ack == 0, "R1 idle after reset", {ready, ack}, 2);

    // read preset contents
    for (int i = 0; i < 16; i++) begin
      access(0, 18'(i) | 18'h2AB00, 8'h00, 0, 0, r);
      chk(r == golden[i], "R2 read preset data", r, golden[i]);
      idle_after();
    end
    // write sweep
    for (int i = 0; i < 64; i++) begin
      golden[i] = 8'((i * 37 + 5) & 8'hFF);
      access(1, 18'(i) | 18'h3FF00, golden[i], 0, 0, r);
      idle_after();
    end
    // read-back sweep
    for (int i = 0; i < 64; i++) begin
      access(0, 18'(i), 8'h00, 0, 0, r);
      chk(r == golden[i], "R5 stored byte read back", r, golden[i]);
      idle_after();
    end
    // back-to-back alternating write/read, chip select held low
    for (int i = 0; i < 16; i++) begin
      golden[i] = 8'(8'hC3 ^ (i * 11));
      access(1, 18'(i), golden[i], 0, i != 0, r);
      chk(ce_n == 0, "R8 chip select low in ack clock", ce_n, 0);
      access(0, 18'(i), 8'h00, 0, 1, r);
      chk(r == golden[i], "R8 back-to-back read data", r, golden[i]);
    end
    idle_after();
    // requests while busy are ignored
    access(1, 18'd5, 8'h5A, 1, 0, r); golden[5] = 8'h5A;
    idle_after();
    access(0, 18'd9, 8'h00, 1, 0, r);
    chk(r == golden[9], "R7 read during poke", r, golden[9]);
    idle_after();
    access(0, 18'd63, 8'h00, 0, 0, r);
    chk(r == golden[63], "R7 busy request ignored", r, golden[63]);
    idle_after();
    access(0, 18'd5, 8'h00, 0, 0, r);
    chk(r == 8'h5A, "R5 write with poke stored", r, 8'h5A);
    idle_after();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule